// File: doc/BRIEF.md
# Burst Column Address Generator

This block works out the column addresses for one read or write burst of a double-data-rate SDRAM. A start strobe captures a column address together with a burst-length code and a burst-order bit. The block then emits the burst two beats per clock: an even beat and an odd beat on paired outputs, to match a two-word prefetch. The low column bits wrap inside an aligned window as wide as the burst. All column bits above that window keep the value from the start address.

The consumer steps through the burst with an advance input, one beat pair per cycle. It can cut the burst short with a terminate input. It can also restart it at any time with a fresh start strobe. A burst-length code outside the supported set raises an error flag, and the burst then runs as two beats. Data movement, strobe timing and the storage array belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: The burst-length code values 1, 2, 3 and 4 select bursts of 2, 4, 8 and 16 beats (1, 2, 4 and 8 beat pairs). `last_pair` is high on the final pair of a burst that is not terminated.
- R2: The codes 0, 5, 6 and 7 are reserved. Each of them sets `bl_err` and gives a 2-beat burst. `bl_err` is captured at each start and holds until the next start, so a start with a supported code clears it.
- R3: With `burst_order` = 0 (sequential), the low window bits of beat k equal (start offset + k) modulo the burst length. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R4: With `burst_order` = 1 (interleaved), the low window bits of beat k equal the start offset XOR k. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R5: The column bits above the burst window equal those of the start address on every beat.
- R6: `col_even` carries beat 2p and `col_odd` carries beat 2p+1 of pair p. Pair 0 appears, with `pair_valid` high, in the cycle after the start strobe. The next pair appears after each cycle in which `advance` is high. While `advance` is low, the pair holds.
- R7: When `terminate` is high while `pair_valid` is high, `last_pair` is high in that same cycle and `pair_valid` is low in the next cycle.
- R8: A start strobe during a burst restarts the sequence at the new address, showing its pair 0 in the next cycle. A start has priority over `terminate` in the same cycle.
- R9: After reset, `pair_valid`, `last_pair` and `bl_err` are low. After the last pair is advanced past, `pair_valid` goes low. While no burst is active, `advance` and `terminate` leave `pair_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin (or restart) a burst at `start_col` |
| start_col | input | 9 | Start column address |
| bl_code | input | 3 | Burst-length code, sampled with `start` |
| burst_order | input | 1 | 0 sequential, 1 interleaved, sampled with `start` |
| advance | input | 1 | Consume the current beat pair |
| terminate | input | 1 | Make the current pair the last one |
| col_even | output | 9 | Column of the even beat of the current pair |
| col_odd | output | 9 | Column of the odd beat of the current pair |
| pair_valid | output | 1 | A beat pair is being presented |
| last_pair | output | 1 | Current pair is the final one of the burst |
| bl_err | output | 1 | Latest start used a reserved length code |

## Verification
The bench sweeps every start offset within a 16-beat window through all eight length codes and both orders, with the upper column bits varied. A design that wraps at the wrong width, or that lets a carry out of the window reach the upper bits, shows a wrong column on some beat. Reserved codes are run to catch a design that falls back to some length other than 2, or that leaves the error flag stale after a later valid start. Stalls, termination at each pair of a 16-beat burst, restart mid-burst, start colliding with terminate, and stray advance or terminate while idle are driven. These catch designs that skip pairs, end late, keep the old address, or wake up without a start.

// File: rtl/bcg_pkg.sv
// Shared types for the burst column address generator.
package bcg_pkg;
    // Order of beats inside the burst window.
    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_XOR = 1'b1
    } burst_order_e;

    // Width of the burst-length code field.
    localparam int unsigned BL_CODE_W = 3;
    typedef logic [BL_CODE_W-1:0] bl_code_t;
endpackage

// File: rtl/bcg_len_decode.sv
// Burst-length code decoder.
// Maps a length code to log2 of the beat count.
// Code n in 1..BL_LOG_MAX means 2**n beats; any other code is flagged
// reserved and decodes as 2 beats.
// Assumes BL_LOG_MAX fits in the code field.
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int unsigned BL_LOG_MAX = 4,
    parameter int unsigned LOG_W      = $clog2(BL_LOG_MAX + 1)
) (
    input  bl_code_t         code,
    output logic [LOG_W-1:0] len_log,
    output logic             reserved
);
    // Range check of the code and fallback to the shortest burst.
    always_comb begin
        if (code >= bl_code_t'(1) && code <= bl_code_t'(BL_LOG_MAX)) begin
            len_log  = LOG_W'(code);
            reserved = 1'b0;
        end else begin
            len_log  = LOG_W'(1);
            reserved = 1'b1;
        end
    end
endmodule

// File: rtl/bcg_beat_addr.sv
// Column address of one beat.
// Combines the captured base column, the burst window size and the beat
// index into a column. Bits above the window come from the base
// unchanged. The low bits either count up with wrap or are XORed with
// the beat index.
// Assumes beat < 2**len_log and COL_W >= BL_LOG_MAX.
module bcg_beat_addr
    import bcg_pkg::*;
#(
    parameter int unsigned COL_W      = 9,
    parameter int unsigned BL_LOG_MAX = 4,
    parameter int unsigned LOG_W      = $clog2(BL_LOG_MAX + 1)
) (
    input  logic [COL_W-1:0]      base_col,
    input  logic [LOG_W-1:0]      len_log,
    input  burst_order_e          order,
    input  logic [BL_LOG_MAX-1:0] beat,
    output logic [COL_W-1:0]      col
);
    logic [COL_W-1:0] win_mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] pick;

    // Window mask, then pick the wrapped sum or the XOR, then merge the high bits back.
    always_comb begin
        win_mask = (COL_W'(1) << len_log) - COL_W'(1);
        beat_ext = COL_W'(beat);
        pick     = (order == ORDER_XOR) ? (base_col ^ beat_ext)
                                        : (base_col + beat_ext);
        col      = (base_col & ~win_mask) | (pick & win_mask);
    end
endmodule

// File: rtl/bcg_pair_seq.sv
// Beat-pair sequencer.
// Holds the context of the running burst (base column, length, order,
// error) and the index of the pair on show. A start always reloads it.
// Otherwise the burst ends after the last pair is advanced, or at once
// on terminate.
// Assumes BL_LOG_MAX >= 2, so the pair index is at least one bit.
module bcg_pair_seq
    import bcg_pkg::*;
#(
    parameter int unsigned COL_W      = 9,
    parameter int unsigned BL_LOG_MAX = 4,
    parameter int unsigned LOG_W      = $clog2(BL_LOG_MAX + 1),
    parameter int unsigned PAIR_W     = BL_LOG_MAX - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [LOG_W-1:0]  dec_log,
    input  logic              dec_err,
    input  burst_order_e      order_in,
    input  logic              advance,
    input  logic              terminate,
    output logic              active,
    output logic [PAIR_W-1:0] pair_idx,
    output logic [COL_W-1:0]  base_col,
    output logic [LOG_W-1:0]  len_log,
    output burst_order_e      order,
    output logic              err,
    output logic              at_last
);
    logic [PAIR_W-1:0] last_idx;

    // Index of the final pair for the captured length.
    always_comb begin
        last_idx = (PAIR_W'(1) << (len_log - LOG_W'(1))) - PAIR_W'(1);
        at_last  = (pair_idx == last_idx);
    end

    // Burst context capture, pair stepping and end of burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            pair_idx <= '0;
            base_col <= '0;
            len_log  <= LOG_W'(1);
            order    <= ORDER_SEQ;
            err      <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            pair_idx <= '0;
            base_col <= start_col;
            len_log  <= dec_log;
            order    <= order_in;
            err      <= dec_err;
        end else if (active && (terminate || (advance && at_last))) begin
            active   <= 1'b0;
            pair_idx <= '0;
        end else if (active && advance) begin
            pair_idx <= pair_idx + PAIR_W'(1);
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
// Burst column address generator, top level.
// Emits a burst two beats per cycle: the even beat on col_even and the
// odd beat on col_odd. Pair 0 appears the cycle after start. last_pair
// follows terminate in the same cycle.
// Assumes the consumer samples outputs only while pair_valid is high.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int unsigned COL_W      = 9,
    parameter int unsigned BL_LOG_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             burst_order,
    input  logic             advance,
    input  logic             terminate,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             pair_valid,
    output logic             last_pair,
    output logic             bl_err
);
    localparam int unsigned LOG_W  = $clog2(BL_LOG_MAX + 1);
    localparam int unsigned PAIR_W = BL_LOG_MAX - 1;
    localparam int unsigned LANES  = 2;

    logic [LOG_W-1:0]  dec_log;
    logic              dec_err;
    logic              active;
    logic [PAIR_W-1:0] pair_idx;
    logic [COL_W-1:0]  base_col;
    logic [LOG_W-1:0]  len_log;
    burst_order_e      order;
    logic              at_last;
    logic [COL_W-1:0]  lane_col [LANES];

    bcg_len_decode #(.BL_LOG_MAX(BL_LOG_MAX), .LOG_W(LOG_W)) u_dec (
        .code     (bl_code_t'(bl_code)),
        .len_log  (dec_log),
        .reserved (dec_err)
    );

    bcg_pair_seq #(
        .COL_W(COL_W), .BL_LOG_MAX(BL_LOG_MAX), .LOG_W(LOG_W), .PAIR_W(PAIR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .dec_log   (dec_log),
        .dec_err   (dec_err),
        .order_in  (burst_order_e'(burst_order)),
        .advance   (advance),
        .terminate (terminate),
        .active    (active),
        .pair_idx  (pair_idx),
        .base_col  (base_col),
        .len_log   (len_log),
        .order     (order),
        .err       (bl_err),
        .at_last   (at_last)
    );

    // One address lane per beat of the pair; the lane number is the low beat bit.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bcg_beat_addr #(
            .COL_W(COL_W), .BL_LOG_MAX(BL_LOG_MAX), .LOG_W(LOG_W)
        ) u_addr (
            .base_col (base_col),
            .len_log  (len_log),
            .order    (order),
            .beat     ({pair_idx, 1'(g)}),
            .col      (lane_col[g])
        );
    end

    // Output mapping of lanes and end-of-burst flag.
    always_comb begin
        col_even   = lane_col[0];
        col_odd    = lane_col[1];
        pair_valid = active;
        last_pair  = active && (at_last || terminate);
    end
endmodule

// File: rtl/bcg_checker.sv
// Checker for the burst column address generator; bound to every instance.
// Observes ports only.
module bcg_checker #(
    parameter int unsigned COL_W      = 9,
    parameter int unsigned BL_LOG_MAX = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             advance,
    input logic             terminate,
    input logic [COL_W-1:0] col_even,
    input logic [COL_W-1:0] col_odd,
    input logic             pair_valid,
    input logic             last_pair,
    input logic             bl_err
);
    // R7: terminate without start ends the burst at the next edge.
    a_r7_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid && terminate && !start |=> !pair_valid);

    // R1: advancing past the last pair ends the burst.
    a_r1_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid && advance && last_pair && !start |=> !pair_valid);

    // R6: with no advance, terminate or start, the pair holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid && !advance && !terminate && !start
        |=> $stable(col_even) && $stable(col_odd) && pair_valid);

    // R6: the two beats of a pair differ in the lowest column bit.
    a_r6_pair_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> col_even[0] != col_odd[0]);

    // R5: both beats share the bits above the widest window.
    a_r5_upper: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> col_even[COL_W-1:BL_LOG_MAX] == col_odd[COL_W-1:BL_LOG_MAX]);

    // R8: a start always shows a pair in the next cycle.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pair_valid);

    // R9: no burst appears without a start.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid && !start |=> !pair_valid);

    // R2: the error flag only changes on a start.
    a_r2_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(bl_err));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .BL_LOG_MAX(BL_LOG_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .advance    (advance),
    .terminate  (terminate),
    .col_even   (col_even),
    .col_odd    (col_odd),
    .pair_valid (pair_valid),
    .last_pair  (last_pair),
    .bl_err     (bl_err)
);

// File: tb/burst_col_gen_test.sv
// Self-checking bench: sweeps start offsets, codes and orders, and drives
// stalls, termination, restart and idle strobes.
module burst_col_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       bl_code = 3'd0;
    logic             burst_order = 1'b0;
    logic             advance = 1'b0;
    logic             terminate = 1'b0;
    logic [COL_W-1:0] col_even;
    logic [COL_W-1:0] col_odd;
    logic             pair_valid;
    logic             last_pair;
    logic             bl_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    burst_col_gen #(.COL_W(COL_W), .BL_LOG_MAX(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .bl_code(bl_code), .burst_order(burst_order), .advance(advance),
        .terminate(terminate), .col_even(col_even), .col_odd(col_odd),
        .pair_valid(pair_valid), .last_pair(last_pair), .bl_err(bl_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected column of beat k: wrapped sum or XOR inside the window.
    function automatic int exp_col(int s, int lg, int ty, int k);
        int win  = 1 << lg;
        int base = (s / win) * win;
        int low  = s % win;
        int off  = (ty != 0) ? (low ^ k) : ((low + k) % win);
        return base + off;
    endfunction

    function automatic int exp_lg(int code);
        return (code >= 1 && code <= 4) ? code : 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic launch(input int s, input int code, input int ty);
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(s); bl_code = 3'(code);
        burst_order = ty[0]; advance = 1'b0; terminate = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run a whole burst; stall idles one cycle on each pair; term_at < 0 means no terminate.
    task automatic run_burst(input int s, input int code, input int ty,
                             input bit stall, input int term_at);
        int lg = exp_lg(code);
        int np = 1 << (lg - 1);
        int p = 0;
        bit visited = 1'b0;
        bit done = 1'b0;
        string oreq = (ty != 0) ? "R4" : "R3";
        launch(s, code, ty);
        while (!done) begin
            bit adv = !(stall && !visited);
            bit trm = adv && (p == term_at);
            advance = adv; terminate = trm;
            #1;
            check("R6 valid", int'(pair_valid), 1);
            check({oreq, "/R5/R6 even"}, int'(col_even), exp_col(s, lg, ty, 2 * p));
            check({oreq, "/R5/R6 odd"}, int'(col_odd), exp_col(s, lg, ty, 2 * p + 1));
            check(trm ? "R7 last" : "R1 last", int'(last_pair),
                  int'((p == np - 1) || trm));
            check("R2 err", int'(bl_err), int'(!(code >= 1 && code <= 4)));
            @(negedge clk);
            if (adv) begin
                if (p == np - 1 || trm) done = 1'b1;
                else begin p++; visited = 1'b0; end
            end else begin
                visited = 1'b1;
            end
        end
        advance = 1'b0; terminate = 1'b0;
        #1;
        check(term_at >= 0 ? "R7 ended" : "R9 ended", int'(pair_valid), 0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 reset valid", int'(pair_valid), 0);
        check("R9 reset last", int'(last_pair), 0);
        check("R9 reset err", int'(bl_err), 0);

        // R9: stray strobes while idle.
        @(negedge clk);
        advance = 1'b1; terminate = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check("R9 idle valid", int'(pair_valid), 0);
        end
        advance = 1'b0; terminate = 1'b0;

        // Sweep: R1 R2 R3 R4 R5 R6 over offsets, codes and orders.
        for (int ty = 0; ty < 2; ty++)
            for (int code = 0; code < 8; code++)
                for (int s = 0; s < 16; s++)
                    run_burst(s + 16 * ((s * 7 + code * 3 + ty) % 32), code, ty, 1'b0, -1);

        // R6 stalls on each pair.
        run_burst(9'h1A5, 3, 0, 1'b1, -1);
        run_burst(9'h0B3, 4, 1, 1'b1, -1);
        run_burst(9'h07E, 6, 1, 1'b1, -1);

        // R7 termination at every pair of a 16-beat burst.
        for (int t = 0; t < 8; t++) begin
            run_burst(9'h1A3 + t, 4, t % 2, 1'b0, t);
        end

        // R8 restart mid-burst at a new address.
        launch(9'h05C, 3, 0);
        advance = 1'b1;
        @(negedge clk);
        start = 1'b1; start_col = 9'h137; bl_code = 3'd2; burst_order = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        #1;
        check("R8 restart valid", int'(pair_valid), 1);
        check("R8 restart even", int'(col_even), exp_col(9'h137, 2, 1, 0));
        check("R8 restart odd", int'(col_odd), exp_col(9'h137, 2, 1, 1));
        check("R8 restart last", int'(last_pair), 0);
        check("R8 restart err", int'(bl_err), 0);

        // R8 start wins over terminate in the same cycle.
        start = 1'b1; terminate = 1'b1; start_col = 9'h0F9; bl_code = 3'd3; burst_order = 1'b0;
        @(negedge clk);
        start = 1'b0; terminate = 1'b0;
        #1;
        check("R8 start over terminate valid", int'(pair_valid), 1);
        check("R8 start over terminate even", int'(col_even), exp_col(9'h0F9, 3, 0, 0));
        check("R8 start over terminate odd", int'(col_odd), exp_col(9'h0F9, 3, 0, 1));
        advance = 1'b1;
        @(negedge clk); #1;
        check("R8 new burst pair1 even", int'(col_even), exp_col(9'h0F9, 3, 0, 2));
        repeat (3) @(negedge clk);
        advance = 1'b0;
        #1;
        check("R9 after last", int'(pair_valid), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule